// File: doc/BRIEF.md
# Precision Time Protocol System Clock Counter

The block keeps a running time of day as a 32-bit seconds count and a 31-bit sub-second count. Every clock it may add a programmable sub-second increment. A carry out of the sub-second field rolls it over and bumps the seconds. Two clocking modes are available. In coarse mode the increment is added on every clock. In fine mode a 32-bit phase accumulator adds an active addend each clock, and the increment is added only on the clocks where that accumulator carries out, so software can trim the frequency.

Software reaches the block through a plain word-wide write port and a combinational read port. It writes the target values first and then sets a command bit in the control register. A small command state machine (states IDLE, INIT, STEP, ADDEND) then takes over. A command written in IDLE moves it to the matching state for exactly one clock, during which the action is applied. It then returns to IDLE, and the command bit reads back as 0 from then on. The transitions are IDLE→INIT, IDLE→STEP and IDLE→ADDEND on an accepted command write, and INIT/STEP/ADDEND→IDLE unconditionally. A time step can move the clock forward or back. To move it back, software uses a complemented encoding so that the hardware only ever adds modulo the field sizes.

Top module: `ptp_systime`

## Requirements
- R1: Register map by word address: 0 control, 1 increment (bits 7:0), 2 addend, 3 seconds update, 4 sub-second update, 5 current seconds, 6 current sub-seconds. After reset every one of them reads 0.
- R2: In coarse mode (control bit 0 = 0) the increment is added to the sub-second count on every clock that carries no command action.
- R3: In fine mode (control bit 0 = 1) the increment is added only on clocks where the 32-bit accumulator, which adds the active addend every clock, carries out. An active addend of 2^31 gives one advance every two clocks, and an active addend of 0 gives none.
- R4: With control bit 1 = 0 (binary format) the sub-second count wraps at 2^31 and the seconds increment on the wrap.
- R5: With control bit 1 = 1 (decimal format) the sub-second count wraps at 1,000,000,000 and the seconds increment on the wrap.
- R6: Writing control bit 2 (initialize) loads both counts from the update registers. The bit reads 1 for the one clock before the load and 0 afterwards, and that clock adds no increment.
- R7: Writing control bit 3 (step) with bit 31 of the sub-second update register clear adds the update values to the time, carrying into seconds on a sub-second wrap. The bit clears itself after one clock.
- R8: With bit 31 of the sub-second update register set, a step subtracts. Seconds are supplied as 2^32 minus the amount, and bits 30:0 as the wrap value minus the amount. The seconds lose one more when the sub-second sum does not reach the wrap value.
- R9: Writing control bit 4 copies the addend register into the active addend after one clock, and the bit then clears. Writing the addend register alone does not change the advance rate.
- R10: A command write while a command is in progress is ignored. When several command bits are set in one write, initialize wins over step and step wins over addend load, and only the winner is carried out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data, combinational |

## Verification
A stuck command state shows at once as a control command bit that stays at 1 past the single busy clock. It also shows as time values that neither load nor step. A wrong rollover limit or a lost carry shows in the current seconds and sub-seconds on the very clock the increment crosses the wrap. A wrong accumulator or a stale active addend shows as a sub-second advance rate that is off within a few clocks in fine mode. The subtract encoding is checked with and without a borrow, so a misplaced borrow shows as a seconds value one off on the clock after the step.

// File: rtl/ptp_systime_pkg.sv
package ptp_systime_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_STEP,
        ST_ADDEND
    } cmd_state_e;

    // control register bit positions
    localparam int unsigned CB_FINE   = 0;
    localparam int unsigned CB_DEC    = 1;
    localparam int unsigned CB_INIT   = 2;
    localparam int unsigned CB_STEP   = 3;
    localparam int unsigned CB_ADDEND = 4;

    // register word addresses
    localparam int unsigned RA_CTRL   = 0;
    localparam int unsigned RA_INC    = 1;
    localparam int unsigned RA_ADDEND = 2;
    localparam int unsigned RA_USEC   = 3;
    localparam int unsigned RA_USUB   = 4;
    localparam int unsigned RA_SEC    = 5;
    localparam int unsigned RA_SUB    = 6;

    localparam int unsigned DEC_WRAP  = 1_000_000_000;

endpackage

// File: rtl/ptp_cmd_fsm.sv
module ptp_cmd_fsm
    import ptp_systime_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       req_init,
    input  logic       req_step,
    input  logic       req_addend,
    output logic       do_init,
    output logic       do_step,
    output logic       do_addend,
    output logic [2:0] busy_vec
);

    cmd_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr) begin
                    if (req_init)        state_d = ST_INIT;
                    else if (req_step)   state_d = ST_STEP;
                    else if (req_addend) state_d = ST_ADDEND;
                end
            end
            ST_INIT, ST_STEP, ST_ADDEND: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        do_init   = (state_q == ST_INIT);
        do_step   = (state_q == ST_STEP);
        do_addend = (state_q == ST_ADDEND);
        busy_vec  = {do_addend, do_step, do_init};
    end

endmodule

// File: rtl/ptp_accum.sv
module ptp_accum #(
    parameter int unsigned ADD_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fine_mode,
    input  logic             load_addend,
    input  logic [ADD_W-1:0] new_addend,
    output logic             tick_en,
    output logic [ADD_W-1:0] act_addend
);

    logic [ADD_W-1:0] acc_q;
    logic [ADD_W:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, act_addend};
    assign tick_en = fine_mode ? acc_sum[ADD_W] : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            act_addend <= '0;
        end else begin
            acc_q <= acc_sum[ADD_W-1:0];
            if (load_addend) act_addend <= new_addend;
        end
    end

endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_systime_pkg::*;
#(
    parameter int unsigned SEC_W = 32,
    parameter int unsigned SUB_W = 31,
    parameter int unsigned INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_mode,
    input  logic             tick_en,
    input  logic [INC_W-1:0] inc,
    input  logic             do_init,
    input  logic             do_step,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [SUB_W-1:0] upd_sub,
    input  logic             upd_neg,
    output logic [SEC_W-1:0] sec_now,
    output logic [SUB_W-1:0] sub_now
);

    localparam logic [SUB_W:0] BIN_LIM = (SUB_W+1)'(1) << SUB_W;
    localparam logic [SUB_W:0] DEC_LIM = (SUB_W+1)'(DEC_WRAP);

    logic [SUB_W:0]   wrap_lim;
    logic [SUB_W:0]   tick_sum, step_sum;
    logic             tick_wrap, step_wrap;
    logic [SEC_W-1:0] step_adj;

    always_comb begin
        wrap_lim  = dec_mode ? DEC_LIM : BIN_LIM;
        tick_sum  = {1'b0, sub_now} + (SUB_W+1)'(inc);
        tick_wrap = (tick_sum >= wrap_lim);
        step_sum  = {1'b0, sub_now} + {1'b0, upd_sub};
        step_wrap = (step_sum >= wrap_lim);
        if (upd_neg) step_adj = step_wrap ? '0 : '1;
        else         step_adj = step_wrap ? SEC_W'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_now <= '0;
            sub_now <= '0;
        end else if (do_init) begin
            sec_now <= upd_sec;
            sub_now <= upd_sub;
        end else if (do_step) begin
            sec_now <= sec_now + upd_sec + step_adj;
            sub_now <= step_wrap ? SUB_W'(step_sum - wrap_lim) : SUB_W'(step_sum);
        end else if (tick_en) begin
            sec_now <= tick_wrap ? sec_now + SEC_W'(1) : sec_now;
            sub_now <= tick_wrap ? SUB_W'(tick_sum - wrap_lim) : SUB_W'(tick_sum);
        end
    end

endmodule

// File: rtl/ptp_systime.sv
module ptp_systime
    import ptp_systime_pkg::*;
#(
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned INC_W  = 8,
    parameter int unsigned ADD_W  = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);

    localparam int unsigned DATA_W = 32;
    localparam int unsigned SUB_W  = DATA_W - 1;

    logic              mode_fine, mode_dec;
    logic [INC_W-1:0]  inc_q;
    logic [ADD_W-1:0]  add_q;
    logic [SEC_W-1:0]  usec_q;
    logic [DATA_W-1:0] usub_q;

    logic              ctrl_wr;
    logic              do_init, do_step, do_addend;
    logic [2:0]        busy_vec;
    logic              tick_en;
    logic [ADD_W-1:0]  act_addend;
    logic [SEC_W-1:0]  sec_now;
    logic [SUB_W-1:0]  sub_now;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(RA_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_fine <= 1'b0;
            mode_dec  <= 1'b0;
            inc_q     <= '0;
            add_q     <= '0;
            usec_q    <= '0;
            usub_q    <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(RA_CTRL)) begin
                mode_fine <= wr_data[CB_FINE];
                mode_dec  <= wr_data[CB_DEC];
            end
            if (wr_addr == ADDR_W'(RA_INC))    inc_q  <= wr_data[INC_W-1:0];
            if (wr_addr == ADDR_W'(RA_ADDEND)) add_q  <= wr_data[ADD_W-1:0];
            if (wr_addr == ADDR_W'(RA_USEC))   usec_q <= wr_data[SEC_W-1:0];
            if (wr_addr == ADDR_W'(RA_USUB))   usub_q <= wr_data;
        end
    end

    ptp_cmd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .req_init   (wr_data[CB_INIT]),
        .req_step   (wr_data[CB_STEP]),
        .req_addend (wr_data[CB_ADDEND]),
        .do_init    (do_init),
        .do_step    (do_step),
        .do_addend  (do_addend),
        .busy_vec   (busy_vec)
    );

    ptp_accum #(.ADD_W(ADD_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .fine_mode   (mode_fine),
        .load_addend (do_addend),
        .new_addend  (add_q),
        .tick_en     (tick_en),
        .act_addend  (act_addend)
    );

    ptp_time_core #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_mode (mode_dec),
        .tick_en  (tick_en),
        .inc      (inc_q),
        .do_init  (do_init),
        .do_step  (do_step),
        .upd_sec  (usec_q),
        .upd_sub  (usub_q[SUB_W-1:0]),
        .upd_neg  (usub_q[DATA_W-1]),
        .sec_now  (sec_now),
        .sub_now  (sub_now)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(RA_CTRL):   rd_data = DATA_W'({busy_vec, mode_dec, mode_fine});
            ADDR_W'(RA_INC):    rd_data = DATA_W'(inc_q);
            ADDR_W'(RA_ADDEND): rd_data = DATA_W'(add_q);
            ADDR_W'(RA_USEC):   rd_data = DATA_W'(usec_q);
            ADDR_W'(RA_USUB):   rd_data = usub_q;
            ADDR_W'(RA_SEC):    rd_data = DATA_W'(sec_now);
            ADDR_W'(RA_SUB):    rd_data = DATA_W'(sub_now);
            default:            rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ptp_systime_chk.sv
module ptp_systime_chk #(
    parameter int unsigned SEC_W = 32,
    parameter int unsigned SUB_W = 31,
    parameter int unsigned INC_W = 8,
    parameter int unsigned ADD_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       busy_vec,
    input logic             do_init,
    input logic             do_addend,
    input logic             tick_en,
    input logic [INC_W-1:0] inc_q,
    input logic [SEC_W-1:0] usec_q,
    input logic [ADD_W-1:0] add_q,
    input logic [ADD_W-1:0] act_addend,
    input logic [SEC_W-1:0] sec_now,
    input logic [SUB_W-1:0] sub_now
);

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vec != 3'b000) |=> (busy_vec == 3'b000)); // R10

    AST_INIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        do_init |=> (sec_now == $past(usec_q))); // R6

    AST_ADDEND_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        do_addend |=> (act_addend == $past(add_q))); // R9

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && busy_vec == 3'b000) |=> ($stable(sec_now) && $stable(sub_now))); // R3

    AST_TICK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && busy_vec == 3'b000 && inc_q != '0) |=> !$stable(sub_now)); // R2

endmodule

bind ptp_systime ptp_systime_chk #(
    .SEC_W (SEC_W),
    .SUB_W (SUB_W),
    .INC_W (INC_W),
    .ADD_W (ADD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_vec   (busy_vec),
    .do_init    (do_init),
    .do_addend  (do_addend),
    .tick_en    (tick_en),
    .inc_q      (inc_q),
    .usec_q     (usec_q),
    .add_q      (add_q),
    .act_addend (act_addend),
    .sec_now    (sec_now),
    .sub_now    (sub_now)
);

// File: tb/ptp_systime_tb_top.sv
`timescale 1ns/1ps
module ptp_systime_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    localparam logic [31:0] NEG  = 32'h8000_0000;
    localparam logic [31:0] DECW = 32'd1_000_000_000;

    always #2 clk = ~clk;

    ptp_systime dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d (0x%08h) expected %0d (0x%08h)", req, got, got, exp, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic chk_time(input string req, input logic [31:0] s, input logic [31:0] ss);
        logic [31:0] v;
        rd(3'd5, v); check(req, v, s);
        rd(3'd6, v); check(req, v, ss);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v); check("R1 reset", v, 32'd0);
        end
    endtask

    task automatic t_init();
        logic [31:0] v;
        wr(3'd3, 32'd10);
        wr(3'd4, 32'd500);
        wr(3'd0, 32'h4);
        rd(3'd0, v); check("R6 busy bit", v, 32'h4);
        @(negedge clk);
        chk_time("R6 load", 32'd10, 32'd500);
        rd(3'd0, v); check("R6 self clear", v, 32'h0);
    endtask

    task automatic t_coarse();
        logic [31:0] v;
        wr(3'd1, 32'd7);
        rd(3'd1, v); check("R1 inc readback", v, 32'd7);
        rd(3'd6, v); check("R2 before tick", v, 32'd500);
        @(negedge clk); rd(3'd6, v); check("R2 tick 1", v, 32'd507);
        @(negedge clk); rd(3'd6, v); check("R2 tick 2", v, 32'd514);
    endtask

    task automatic t_binary();
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd20);
        wr(3'd4, 32'h7FFF_FFFD);
        wr(3'd0, 32'h4);
        @(negedge clk);
        chk_time("R4 load", 32'd20, 32'h7FFF_FFFD);
        wr(3'd1, 32'd5);
        chk_time("R4 hold", 32'd20, 32'h7FFF_FFFD);
        @(negedge clk);
        chk_time("R4 wrap", 32'd21, 32'd2);
    endtask

    task automatic t_decimal();
        logic [31:0] v;
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd3);
        wr(3'd4, 32'd999_999_995);
        wr(3'd0, 32'h6);
        @(negedge clk);
        rd(3'd0, v); check("R5 mode readback", v, 32'h2);
        wr(3'd1, 32'd7);
        chk_time("R5 hold", 32'd3, 32'd999_999_995);
        @(negedge clk);
        chk_time("R5 wrap", 32'd4, 32'd2);
    endtask

    task automatic t_step_add();
        logic [31:0] v;
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd5);
        wr(3'd4, 32'd999_999_990);
        wr(3'd0, 32'h6);
        @(negedge clk);
        wr(3'd3, 32'd2);
        wr(3'd4, 32'd20);
        wr(3'd0, 32'h2 | 32'h8);
        rd(3'd0, v); check("R7 busy bit", v, 32'hA);
        @(negedge clk);
        chk_time("R7 add with carry", 32'd8, 32'd10);
        rd(3'd0, v); check("R7 self clear", v, 32'h2);
    endtask

    task automatic t_step_sub();
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, NEG | (DECW - 32'd20));
        wr(3'd0, 32'h2 | 32'h8);
        @(negedge clk);
        chk_time("R8 subtract with borrow", 32'd6, 32'd999_999_990);
        wr(3'd3, 32'hFFFF_FFFE);
        wr(3'd4, NEG | 32'd10_000_000);
        wr(3'd0, 32'h2 | 32'h8);
        @(negedge clk);
        chk_time("R8 subtract no borrow", 32'd4, 32'd9_999_990);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        wr(3'd3, 32'd100);
        wr(3'd4, 32'd77);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h2 | 32'h4;
        @(negedge clk);
        wr_data = 32'h2 | 32'h8;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk_time("R10 step ignored while busy", 32'd100, 32'd77);
        rd(3'd0, v); check("R10 no command left", v, 32'h2);
        wr(3'd3, 32'd50);
        wr(3'd4, 32'd5);
        wr(3'd0, 32'h2 | 32'h4 | 32'h8);
        rd(3'd0, v); check("R10 priority busy", v, 32'h6);
        @(negedge clk);
        @(negedge clk);
        chk_time("R10 init wins", 32'd50, 32'd5);
    endtask

    task automatic t_fine();
        logic [31:0] s0, v;
        wr(3'd1, 32'd4);
        wr(3'd0, 32'h3);
        rd(3'd6, s0);
        repeat (4) @(negedge clk);
        rd(3'd6, v); check("R3 zero addend holds", v, s0);
        wr(3'd2, 32'h8000_0000);
        rd(3'd6, s0);
        repeat (4) @(negedge clk);
        rd(3'd6, v); check("R9 addend write alone no effect", v, s0);
        wr(3'd0, 32'h3 | 32'h10);
        rd(3'd0, v); check("R9 busy bit", v, 32'h13);
        @(negedge clk);
        rd(3'd0, v); check("R9 self clear", v, 32'h3);
        rd(3'd6, s0);
        repeat (8) @(negedge clk);
        rd(3'd6, v); check("R3 half rate advance", v - s0, 32'd16);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_coarse();
        t_binary();
        t_decimal();
        t_step_add();
        t_step_sub();
        t_busy();
        t_fine();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule